// File: doc/BRIEF.md
# Exception Entry Vector Unit

This unit takes an exception request from a processor pipeline and computes the whole state change that entering the exception needs. In the cycle the request strobe is high it samples the request code, its qualifiers (refill miss, coprocessor number, branch delay slot), the faulting PC and the current mode bits: exception level, boot vectors, interrupt vectoring, debug mode and the exception base. On the next clock edge it presents the new program counter and the updated save registers.

Requests fall into three classes. General exceptions save EPC and the branch-delay flag when the exception level is clear and write the 5-bit cause code. Reset-class entries (NMI and soft reset) save ErrorEPC. Debug entries save DEPC and set a sticky debug cause bit. Status changes (exception level, error level, boot vectors, NMI, soft-reset, debug mode) come out as one-cycle set pulses for the Status owner to apply. The unit holds the EPC, ErrorEPC, DEPC, Cause code, BD, CE and debug cause fields itself.

Top module: `exc_vector_unit`

## Requirements
- R1: After reset every output register and pulse is zero.
- R2: A request with a known code gives redirect_o high for exactly the one cycle after the sampling edge, with pc_o set to the target. Request codes are: 0 interrupt, 1 modify, 2 TLB load, 3 TLB store, 4 address error load, 5 address error store, 6 instruction bus error, 7 data bus error, 8 syscall, 9 break, 10 reserved instruction, 11 coprocessor unusable, 12 overflow, 13 trap, 15 floating point, 24 machine check, 30 cache error (general, written to exc_code_o as is); 16 soft reset, 17 NMI; 19 debug single step, 20 debug interrupt, 21 debug instruction breakpoint, 26 debug software breakpoint, 27 debug data break load, 28 debug data break store.
- R3: A general exception target is base plus offset. The base is 0xBFC00200 when bev_i is 1, else ebase_i with bits 9:0 cleared. The default offset is 0x180.
- R4: An interrupt (code 0) uses offset 0x200 when iv_i is 1.
- R5: A TLB load or store with refill_i high uses offset 0x000 when exl_i is 0, and 0x180 when exl_i is 1.
- R6: A cache error uses offset 0x100 when bev_i is 1, else 0x20000100.
- R7: A general exception with exl_i 0 loads epc_o with pc_i, or pc_i-4 when delay_slot_i is 1, sets bd_o to delay_slot_i and pulses set_exl_o.
- R8: A general exception with exl_i 1 leaves epc_o and bd_o unchanged and does not pulse set_exl_o.
- R9: Code 11 loads ce_o with cop_i. Every other code leaves ce_o unchanged.
- R10: NMI and soft reset jump to 0xBFC00000, load error_epc_o with the delay-slot adjusted PC, pulse set_erl_o and set_bev_o, and pulse set_nmi_o (NMI) or set_sr_o (soft reset). They clear bd_o when exl_i is 0.
- R11: Debug codes jump to 0xBFC00480 and pulse enter_dm_o. They load depc_o with the delay-slot adjusted PC, except single step, which saves pc_i unadjusted. They set the sticky dbg_cause_o bit: bit0 single step, bit1 software breakpoint, bit2 data break load, bit3 data break store, bit4 instruction breakpoint, bit5 debug interrupt. They clear bd_o when exl_i is 0.
- R12: Code 0 with dm_i 1 is handled as a debug interrupt (code 20).
- R13: Any other code only pulses bad_code_o for one cycle. Every held output and pc_o stays unchanged and no other pulse fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Exception request strobe |
| code_i | input | 5 | Request code |
| refill_i | input | 1 | TLB request is a refill miss |
| cop_i | input | 2 | Coprocessor number for code 11 |
| delay_slot_i | input | 1 | Faulting instruction is in a branch delay slot |
| pc_i | input | 32 | Faulting PC |
| exl_i | input | 1 | Current exception level bit |
| bev_i | input | 1 | Current boot vector bit |
| iv_i | input | 1 | Interrupt vectoring enable |
| dm_i | input | 1 | Currently in debug mode |
| ebase_i | input | 32 | Exception base register |
| redirect_o | output | 1 | Pulse: take pc_o |
| pc_o | output | 32 | Entry PC |
| bad_code_o | output | 1 | Pulse: unknown code ignored |
| epc_o | output | 32 | Exception return PC |
| error_epc_o | output | 32 | Error return PC |
| depc_o | output | 32 | Debug return PC |
| exc_code_o | output | 5 | Cause code |
| bd_o | output | 1 | Cause branch-delay flag |
| ce_o | output | 2 | Cause coprocessor number |
| dbg_cause_o | output | 6 | Sticky debug cause bits |
| set_exl_o | output | 1 | Pulse: set exception level |
| set_erl_o | output | 1 | Pulse: set error level |
| set_bev_o | output | 1 | Pulse: set boot vectors |
| set_nmi_o | output | 1 | Pulse: set NMI status bit |
| set_sr_o | output | 1 | Pulse: set soft-reset status bit |
| enter_dm_o | output | 1 | Pulse: enter debug mode |

## Verification
The bench sweeps every request code against every combination of exception level, boot vectors, delay slot, interrupt vectoring, refill and debug mode. It targets the places where offsets interact. A design that ignores the exception level on a refill sends a nested miss to offset 0x000 and loops through the refill handler. A design that overwrites EPC while exl_i is set loses the original return address. A design that adjusts DEPC on single step returns one instruction early. A design that leaves an interrupt in debug mode as a general exception overwrites EPC. Unknown codes are checked to leave every held field and the PC untouched.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;
  localparam int unsigned CODE_W = 5;
  localparam int unsigned DBG_W  = 6;

  typedef enum logic [2:0] {
    CLS_NONE, CLS_GEN, CLS_NMI, CLS_SRST, CLS_DBG
  } exc_cls_e;

  localparam logic [CODE_W-1:0] C_INT    = 5'd0;
  localparam logic [CODE_W-1:0] C_TLBL   = 5'd2;
  localparam logic [CODE_W-1:0] C_TLBS   = 5'd3;
  localparam logic [CODE_W-1:0] C_CPU    = 5'd11;
  localparam logic [CODE_W-1:0] C_CACHE  = 5'd30;
  localparam logic [CODE_W-1:0] C_SRST   = 5'd16;
  localparam logic [CODE_W-1:0] C_NMI    = 5'd17;
  localparam logic [CODE_W-1:0] C_DSTEP  = 5'd19;
  localparam logic [CODE_W-1:0] C_DINT   = 5'd20;
  localparam logic [CODE_W-1:0] C_DIBP   = 5'd21;
  localparam logic [CODE_W-1:0] C_DSWBP  = 5'd26;
  localparam logic [CODE_W-1:0] C_DLOAD  = 5'd27;
  localparam logic [CODE_W-1:0] C_DSTORE = 5'd28;
endpackage

// File: rtl/exc_decode.sv
module exc_decode
  import exc_vec_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  logic              dm_i,
  output exc_cls_e          cls_o,
  output logic [CODE_W-1:0] eff_code_o,
  output logic [DBG_W-1:0]  dbg_bit_o,
  output logic              step_o
);
  always_comb begin
    eff_code_o = (code_i == C_INT && dm_i) ? C_DINT : code_i;
    dbg_bit_o  = '0;
    step_o     = 1'b0;
    cls_o      = CLS_NONE;
    unique case (eff_code_o)
      5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd8, 5'd9,
      5'd10, 5'd11, 5'd12, 5'd13, 5'd15, 5'd24, 5'd30: cls_o = CLS_GEN;
      C_SRST:   cls_o = CLS_SRST;
      C_NMI:    cls_o = CLS_NMI;
      C_DSTEP:  begin cls_o = CLS_DBG; dbg_bit_o[0] = 1'b1; step_o = 1'b1; end
      C_DSWBP:  begin cls_o = CLS_DBG; dbg_bit_o[1] = 1'b1; end
      C_DLOAD:  begin cls_o = CLS_DBG; dbg_bit_o[2] = 1'b1; end
      C_DSTORE: begin cls_o = CLS_DBG; dbg_bit_o[3] = 1'b1; end
      C_DIBP:   begin cls_o = CLS_DBG; dbg_bit_o[4] = 1'b1; end
      C_DINT:   begin cls_o = CLS_DBG; dbg_bit_o[5] = 1'b1; end
      default:  cls_o = CLS_NONE;
    endcase
  end
endmodule

// File: rtl/exc_target.sv
module exc_target
  import exc_vec_pkg::*;
#(
  parameter int unsigned    AW         = 32,
  parameter logic [AW-1:0]  BOOT_GEN   = 32'hBFC0_0200,
  parameter logic [AW-1:0]  RESET_VEC  = 32'hBFC0_0000,
  parameter logic [AW-1:0]  DEBUG_VEC  = 32'hBFC0_0480,
  parameter int unsigned    EBASE_LSB  = 10
) (
  input  exc_cls_e          cls_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              refill_i,
  input  logic              exl_i,
  input  logic              bev_i,
  input  logic              iv_i,
  input  logic [AW-1:0]     ebase_i,
  output logic [AW-1:0]     target_o
);
  localparam logic [AW-1:0] EBASE_MASK = ~((AW'(1) << EBASE_LSB) - AW'(1));
  localparam logic [AW-1:0] OFF_GEN    = AW'(32'h180);
  localparam logic [AW-1:0] OFF_IV     = AW'(32'h200);
  localparam logic [AW-1:0] OFF_CBOOT  = AW'(32'h100);
  localparam logic [AW-1:0] OFF_CRUN   = AW'(32'h2000_0100);

  logic [AW-1:0] base, offset;

  always_comb begin
    base   = bev_i ? BOOT_GEN : (ebase_i & EBASE_MASK);
    offset = OFF_GEN;
    if (code_i == C_INT && iv_i)                                      offset = OFF_IV;
    else if ((code_i == C_TLBL || code_i == C_TLBS) && refill_i && !exl_i) offset = '0;
    else if (code_i == C_CACHE)                                       offset = bev_i ? OFF_CBOOT : OFF_CRUN;
    unique case (cls_i)
      CLS_NMI, CLS_SRST: target_o = RESET_VEC;
      CLS_DBG:           target_o = DEBUG_VEC;
      default:           target_o = base + offset;
    endcase
  end
endmodule

// File: rtl/exc_ret_addr.sv
module exc_ret_addr #(
  parameter int unsigned AW     = 32,
  parameter int unsigned INSN_B = 4
) (
  input  logic [AW-1:0] pc_i,
  input  logic          delay_slot_i,
  input  logic          no_adjust_i,
  output logic [AW-1:0] ret_o
);
  // delay-slot faults return to the branch
  assign ret_o = (delay_slot_i && !no_adjust_i) ? pc_i - AW'(INSN_B) : pc_i;
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
  import exc_vec_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              refill_i,
  input  logic [1:0]        cop_i,
  input  logic              delay_slot_i,
  input  logic [AW-1:0]     pc_i,
  input  logic              exl_i,
  input  logic              bev_i,
  input  logic              iv_i,
  input  logic              dm_i,
  input  logic [AW-1:0]     ebase_i,
  output logic              redirect_o,
  output logic [AW-1:0]     pc_o,
  output logic              bad_code_o,
  output logic [AW-1:0]     epc_o,
  output logic [AW-1:0]     error_epc_o,
  output logic [AW-1:0]     depc_o,
  output logic [CODE_W-1:0] exc_code_o,
  output logic              bd_o,
  output logic [1:0]        ce_o,
  output logic [DBG_W-1:0]  dbg_cause_o,
  output logic              set_exl_o,
  output logic              set_erl_o,
  output logic              set_bev_o,
  output logic              set_nmi_o,
  output logic              set_sr_o,
  output logic              enter_dm_o
);
  exc_cls_e          cls;
  logic [CODE_W-1:0] eff_code;
  logic [DBG_W-1:0]  dbg_bit;
  logic              step;
  logic [AW-1:0]     target, ret_pc;

  exc_decode u_dec (
    .code_i(code_i), .dm_i(dm_i), .cls_o(cls), .eff_code_o(eff_code),
    .dbg_bit_o(dbg_bit), .step_o(step)
  );

  exc_target #(.AW(AW)) u_tgt (
    .cls_i(cls), .code_i(eff_code), .refill_i(refill_i), .exl_i(exl_i),
    .bev_i(bev_i), .iv_i(iv_i), .ebase_i(ebase_i), .target_o(target)
  );

  exc_ret_addr #(.AW(AW)) u_ret (
    .pc_i(pc_i), .delay_slot_i(delay_slot_i), .no_adjust_i(step), .ret_o(ret_pc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_o  <= 1'b0;
      pc_o        <= '0;
      bad_code_o  <= 1'b0;
      epc_o       <= '0;
      error_epc_o <= '0;
      depc_o      <= '0;
      exc_code_o  <= '0;
      bd_o        <= 1'b0;
      ce_o        <= '0;
      dbg_cause_o <= '0;
      set_exl_o   <= 1'b0;
      set_erl_o   <= 1'b0;
      set_bev_o   <= 1'b0;
      set_nmi_o   <= 1'b0;
      set_sr_o    <= 1'b0;
      enter_dm_o  <= 1'b0;
    end else begin
      redirect_o <= 1'b0;
      bad_code_o <= 1'b0;
      set_exl_o  <= 1'b0;
      set_erl_o  <= 1'b0;
      set_bev_o  <= 1'b0;
      set_nmi_o  <= 1'b0;
      set_sr_o   <= 1'b0;
      enter_dm_o <= 1'b0;
      if (req_i) begin
        unique case (cls)
          CLS_GEN: begin
            redirect_o <= 1'b1;
            pc_o       <= target;
            exc_code_o <= eff_code;
            if (eff_code == C_CPU) ce_o <= cop_i;
            if (!exl_i) begin
              epc_o     <= ret_pc;
              bd_o      <= delay_slot_i;
              set_exl_o <= 1'b1;
            end
          end
          CLS_NMI, CLS_SRST: begin
            redirect_o  <= 1'b1;
            pc_o        <= target;
            error_epc_o <= ret_pc;
            set_erl_o   <= 1'b1;
            set_bev_o   <= 1'b1;
            set_nmi_o   <= (cls == CLS_NMI);
            set_sr_o    <= (cls == CLS_SRST);
            if (!exl_i) bd_o <= 1'b0;
          end
          CLS_DBG: begin
            redirect_o  <= 1'b1;
            pc_o        <= target;
            depc_o      <= ret_pc;
            dbg_cause_o <= dbg_cause_o | dbg_bit;
            enter_dm_o  <= 1'b1;
            if (!exl_i) bd_o <= 1'b0;
          end
          default: bad_code_o <= 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/exc_vector_unit_chk.sv
module exc_vector_unit_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          exl_i,
  input logic          redirect_o,
  input logic          bad_code_o,
  input logic [AW-1:0] pc_o,
  input logic [AW-1:0] epc_o,
  input logic          bd_o,
  input logic          set_exl_o,
  input logic          set_erl_o,
  input logic          enter_dm_o
);
  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!redirect_o && !bad_code_o));

  p_epc_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && exl_i) |=> ($stable(epc_o) && $stable(bd_o) && !set_exl_o));

  p_one_outcome_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({redirect_o, bad_code_o}));

  p_unknown_inert_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_code_o |-> ($stable(pc_o) && $stable(epc_o) && !set_exl_o && !enter_dm_o));

  p_reset_vec_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_erl_o |-> (redirect_o && pc_o == 32'hBFC0_0000));

  p_debug_vec_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enter_dm_o |-> (redirect_o && pc_o == 32'hBFC0_0480 && !set_exl_o));
endmodule

bind exc_vector_unit exc_vector_unit_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .exl_i(exl_i),
  .redirect_o(redirect_o), .bad_code_o(bad_code_o), .pc_o(pc_o),
  .epc_o(epc_o), .bd_o(bd_o), .set_exl_o(set_exl_o),
  .set_erl_o(set_erl_o), .enter_dm_o(enter_dm_o)
);

// File: tb/exc_vector_unit_test.sv
module exc_vector_unit_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [4:0]  code_i = '0;
  logic        refill_i = 1'b0;
  logic [1:0]  cop_i = '0;
  logic        delay_slot_i = 1'b0;
  logic [31:0] pc_i = '0;
  logic        exl_i = 1'b0, bev_i = 1'b0, iv_i = 1'b0, dm_i = 1'b0;
  logic [31:0] ebase_i = '0;
  logic        redirect_o, bad_code_o, bd_o;
  logic [31:0] pc_o, epc_o, error_epc_o, depc_o;
  logic [4:0]  exc_code_o;
  logic [1:0]  ce_o;
  logic [5:0]  dbg_cause_o;
  logic        set_exl_o, set_erl_o, set_bev_o, set_nmi_o, set_sr_o, enter_dm_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  exc_vector_unit uut (.*);

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] e_pc, e_epc, e_err, e_depc, e_ret, e_off, e_base;
    logic [4:0]  e_code, ecode;
    logic [1:0]  e_ce;
    logic [5:0]  e_dbg, bitv;
    logic        e_bd;
    int          cls; // 0 none 1 gen 2 nmi 3 srst 4 dbg
    string       ptag;
    int          idx;

    repeat (3) @(negedge clk_i);
    // R1 reset state
    cmp("R1 pc", pc_o, 0); cmp("R1 epc", epc_o, 0); cmp("R1 errorepc", error_epc_o, 0);
    cmp("R1 depc", depc_o, 0); cmp("R1 code", 32'(exc_code_o), 0);
    cmp("R1 pulses", 32'({redirect_o, bad_code_o, set_exl_o, set_erl_o, set_bev_o,
                          set_nmi_o, set_sr_o, enter_dm_o, bd_o}), 0);
    cmp("R1 dbg", 32'(dbg_cause_o), 0); cmp("R1 ce", 32'(ce_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    cmp("R2 no request", 32'(redirect_o), 0);

    e_pc = 0; e_epc = 0; e_err = 0; e_depc = 0; e_code = 0; e_ce = 0; e_dbg = 0; e_bd = 0;
    idx = 0;
    for (int code = 0; code < 32; code++)
      for (int st = 0; st < 64; st++) begin
        code_i       = 5'(code);
        exl_i        = st[0];
        bev_i        = st[1];
        delay_slot_i = st[2];
        iv_i         = st[3];
        refill_i     = st[4];
        dm_i         = st[5];
        cop_i        = 2'(idx);
        pc_i         = 32'h0040_0000 + 32'(idx) * 4;
        ebase_i      = 32'h8000_0000 + 32'(idx) * 32'h135;
        idx++;

        ecode = (code == 0 && dm_i) ? 5'd20 : 5'(code);
        bitv = 0;
        case (ecode)
          0,1,2,3,4,5,6,7,8,9,10,11,12,13,15,24,30: cls = 1;
          17: cls = 2;
          16: cls = 3;
          19: begin cls = 4; bitv = 6'b000001; end
          26: begin cls = 4; bitv = 6'b000010; end
          27: begin cls = 4; bitv = 6'b000100; end
          28: begin cls = 4; bitv = 6'b001000; end
          21: begin cls = 4; bitv = 6'b010000; end
          20: begin cls = 4; bitv = 6'b100000; end
          default: cls = 0;
        endcase
        e_ret = (delay_slot_i && ecode != 5'd19) ? pc_i - 4 : pc_i;
        e_base = bev_i ? 32'hBFC0_0200 : {ebase_i[31:10], 10'b0};
        e_off = 32'h180; ptag = "R3 general target";
        if (ecode == 0 && iv_i) begin e_off = 32'h200; ptag = "R4 interrupt target"; end
        else if ((ecode == 2 || ecode == 3) && refill_i) begin
          ptag = "R5 refill target";
          if (!exl_i) e_off = 0;
        end else if (ecode == 30) begin
          e_off = bev_i ? 32'h100 : 32'h2000_0100; ptag = "R6 cache error target";
        end

        req_i = 1'b1;
        @(negedge clk_i);
        req_i = 1'b0;

        if (cls == 0) begin
          cmp("R13 bad_code", 32'(bad_code_o), 1);
          cmp("R13 redirect", 32'(redirect_o), 0);
        end else begin
          cmp("R2 redirect", 32'(redirect_o), 1);
          cmp("R13 bad_code quiet", 32'(bad_code_o), 0);
          case (cls)
            1: begin
              e_pc = e_base + e_off;
              e_code = ecode;
              if (ecode == 11) e_ce = cop_i;
              if (!exl_i) begin e_epc = e_ret; e_bd = delay_slot_i; end
              cmp(exl_i ? "R8 set_exl" : "R7 set_exl", 32'(set_exl_o), exl_i ? 0 : 1);
            end
            2, 3: begin
              e_pc = 32'hBFC0_0000; e_err = e_ret;
              if (!exl_i) e_bd = 1'b0;
              cmp("R10 erl/bev/nmi/sr", 32'({set_erl_o, set_bev_o, set_nmi_o, set_sr_o}),
                  (cls == 2) ? 32'b1110 : 32'b1101);
              ptag = "R10 reset target";
            end
            default: begin
              e_pc = 32'hBFC0_0480; e_depc = e_ret; e_dbg = e_dbg | bitv;
              if (!exl_i) e_bd = 1'b0;
              cmp("R11 enter_dm", 32'(enter_dm_o), 1);
              ptag = (code == 0) ? "R12 debug interrupt target" : "R11 debug target";
            end
          endcase
          cmp(ptag, pc_o, e_pc);
        end
        cmp("R13 pc held", pc_o, e_pc);
        cmp(exl_i ? "R8 epc" : "R7 epc", epc_o, e_epc);
        cmp(exl_i ? "R8 bd" : "R7 bd", 32'(bd_o), 32'(e_bd));
        cmp("R2 exc_code", 32'(exc_code_o), 32'(e_code));
        cmp("R9 ce", 32'(ce_o), 32'(e_ce));
        cmp("R10 errorepc", error_epc_o, e_err);
        cmp("R11 depc", depc_o, e_depc);
        cmp((code == 0 && dm_i) ? "R12 dbg cause" : "R11 dbg cause",
            32'(dbg_cause_o), 32'(e_dbg));

        @(negedge clk_i);
        cmp("R2 single pulse", 32'({redirect_o, bad_code_o, set_exl_o, enter_dm_o}), 0);
      end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule